// File: doc/BRIEF.md
# Access-Type-Aware Cache Insertion Controller

This block sits beside one set-associative last-level cache and decides what happens to the line carried by each request. For a miss, it decides whether the line is installed and which way it replaces. For a hit, it refreshes the way that hit. Demand traffic (loads and stores) follows a predicted cache/bypass bit supplied from outside. When such a line is installed, the victim is picked with a 2-bit re-reference prediction value (RRPV) per way. Writebacks and prefetches are never trained and never bypassed. They always land in way 0, so the victim ordering built up by demand traffic is left alone.

Requests arrive on a valid/ready channel and only one request is in flight at a time. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The result is presented on a second valid/ready channel. While `rsp_ready` is low, `rsp_valid` and the result fields stay held, and no new request is accepted. A one-cycle `train_en` pulse tells an external history trainer that a demand access was accepted.

Access type encoding on `req_type`: 2'b00 load, 2'b01 store, 2'b10 writeback, 2'b11 prefetch.

Top module: `access_aware_insert`

## Requirements
- R1: `req_ready` is high exactly when no request is in flight. Once `rsp_valid` rises, it stays high with `rsp_install` and `rsp_victim` stable until a cycle where `rsp_ready` is high. The block then returns to idle.
- R2: A load (00) or store (01) miss with `req_pred_cache`=0 responds one cycle after acceptance with `rsp_install`=0 and `rsp_victim`=0. It leaves every RRPV of the set unchanged.
- R3: A writeback (10) or prefetch (11) miss responds one cycle after acceptance with `rsp_install`=1 and `rsp_victim`=0. It ignores `req_pred_cache` and leaves every RRPV unchanged.
- R4: A load or store miss with `req_pred_cache`=1 is installed. With all ways valid, the victim is the lowest-index way whose RRPV is 3, and that way's RRPV becomes 2.
- R5: If any bit of `req_way_valid` is 0 on such an install, the victim is the lowest-index invalid way, whatever the RRPVs are. Its RRPV becomes 2.
- R6: When no way holds RRPV 3, all RRPVs of the set are incremented once per clock until one reaches 3. The response therefore comes 2+k cycles after acceptance, where k is the number of increments.
- R7: A hit of any type (`req_hit`=1) sets the RRPV of `req_hit_way` to 0. It responds one cycle after acceptance with `rsp_install`=0 and `rsp_victim` equal to the hit way.
- R8: `train_en` is high for exactly the one cycle after a load or store is accepted, whether it hits or misses. It is never high for a writeback or prefetch.
- R9: After reset every RRPV is 3, `req_ready` is 1, and `rsp_valid` and `train_en` are 0.
- R10: RRPV state is kept per set. A request to one set never changes the victim order of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_type | input | 2 | Access type: 00 load, 01 store, 10 writeback, 11 prefetch |
| req_set | input | $clog2(NUM_SETS) | Set index |
| req_hit | input | 1 | Tag lookup hit |
| req_hit_way | input | $clog2(NUM_WAYS) | Way that hit |
| req_pred_cache | input | 1 | Predictor says install (demand misses only) |
| req_way_valid | input | NUM_WAYS | Per-way valid flags of the set |
| rsp_valid | output | 1 | Result presented |
| rsp_ready | input | 1 | Result consumed |
| rsp_install | output | 1 | 1 install line, 0 bypass or hit |
| rsp_victim | output | $clog2(NUM_WAYS) | Way to replace, or the hit way |
| train_en | output | 1 | One-cycle pulse for the history trainer |

## Verification
The bench checks aging depth in the cycle count: a set whose ways were all refreshed to 0 must take three increment steps before its victim appears. A design that aged only once, or aged in zero time, shows up in the latency. An invalid way must win over an older valid way with RRPV 3. A picker that scanned RRPVs first would name way 0 instead. Writeback and prefetch fills, hits by prefetch, and bypassed demand misses are each followed by demand misses whose victims prove that the RRPVs were left untouched. The bench also holds the response under back-pressure to show that fields stay stable and no request slips in, and it compares two sets to show their state stays separate.

// File: rtl/aai_pkg.sv
package aai_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_WBACK = 2'b10,
    ACC_PREF  = 2'b11
  } acc_t;

  localparam int RRPV_W = 2;
  localparam logic [RRPV_W-1:0] RRPV_MAX  = 2'd3;
  localparam logic [RRPV_W-1:0] RRPV_FILL = 2'd2;
  localparam logic [RRPV_W-1:0] RRPV_HIT  = 2'd0;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_RESP   = 2'd2
  } ctl_state_t;

  function automatic logic is_demand(input logic [1:0] t);
    return (t == ACC_LOAD) || (t == ACC_STORE);
  endfunction
endpackage

// File: rtl/aai_rrpv_bank.sv
module aai_rrpv_bank
  import aai_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(SETS)-1:0]       acc_set,
  input  logic                          wr_en,
  input  logic [$clog2(WAYS)-1:0]       wr_way,
  input  logic [RRPV_W-1:0]             wr_val,
  input  logic                          age_en,
  output logic [WAYS-1:0][RRPV_W-1:0]   rd_rrpv
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [SETS-1:0][WAYS-1:0][RRPV_W-1:0] mem;
  logic any_max;

  assign rd_rrpv = mem[acc_set];

  always_comb begin
    any_max = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (rd_rrpv[w] == RRPV_MAX) any_max = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '1;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (SET_W'(s) == acc_set) begin
            if (wr_en && (wr_way == WAY_W'(w)))
              mem[s][w] <= wr_val;
            else if (age_en && (mem[s][w] != RRPV_MAX))
              mem[s][w] <= mem[s][w] + 1'b1;
          end
        end
      end
    end
  end

  AST_AGE_ONLY_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    age_en |-> !any_max); // R6
  AST_NO_WRITE_WHILE_AGING: assert property (@(posedge clk) disable iff (!rst_n)
    age_en |-> !wr_en); // R6
endmodule

// File: rtl/aai_victim_pick.sv
module aai_victim_pick
  import aai_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0][RRPV_W-1:0] rrpv,
  input  logic [WAYS-1:0]             way_valid,
  output logic                        found,
  output logic [$clog2(WAYS)-1:0]     way
);
  localparam int WAY_W = $clog2(WAYS);

  logic inv_any;

  always_comb begin
    inv_any = |(~way_valid);
    found   = 1'b0;
    way     = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (inv_any ? !way_valid[w] : (rrpv[w] == RRPV_MAX)) begin
        found = 1'b1;
        way   = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/access_aware_insert.sv
module access_aware_insert
  import aai_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_type,
  input  logic [$clog2(NUM_SETS)-1:0]   req_set,
  input  logic                          req_hit,
  input  logic [$clog2(NUM_WAYS)-1:0]   req_hit_way,
  input  logic                          req_pred_cache,
  input  logic [NUM_WAYS-1:0]           req_way_valid,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic                          rsp_install,
  output logic [$clog2(NUM_WAYS)-1:0]   rsp_victim,
  output logic                          train_en
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);

  ctl_state_t                         state;
  logic [1:0]                         q_type;
  logic [SET_W-1:0]                   q_set;
  logic [NUM_WAYS-1:0]                q_mask;
  logic                               accept;
  logic                               acc_demand;
  logic [SET_W-1:0]                   bank_set;
  logic                               bank_wr;
  logic [WAY_W-1:0]                   bank_way;
  logic [RRPV_W-1:0]                  bank_val;
  logic                               bank_age;
  logic [NUM_WAYS-1:0][RRPV_W-1:0]    set_rrpv;
  logic                               pick_found;
  logic [WAY_W-1:0]                   pick_way;

  assign req_ready  = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_RESP);
  assign accept     = req_valid && req_ready;
  assign acc_demand = is_demand(req_type);
  assign bank_set   = (state == ST_IDLE) ? req_set : q_set;

  always_comb begin
    bank_wr  = 1'b0;
    bank_way = '0;
    bank_val = RRPV_HIT;
    bank_age = 1'b0;
    if (accept && req_hit) begin
      bank_wr  = 1'b1;
      bank_way = req_hit_way;
      bank_val = RRPV_HIT;
    end else if (state == ST_SEARCH) begin
      if (pick_found) begin
        bank_wr  = 1'b1;
        bank_way = pick_way;
        bank_val = RRPV_FILL;
      end else begin
        bank_age = 1'b1;
      end
    end
  end

  aai_rrpv_bank #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_set (bank_set),
    .wr_en   (bank_wr),
    .wr_way  (bank_way),
    .wr_val  (bank_val),
    .age_en  (bank_age),
    .rd_rrpv (set_rrpv)
  );

  aai_victim_pick #(.WAYS(NUM_WAYS)) u_pick (
    .rrpv      (set_rrpv),
    .way_valid (q_mask),
    .found     (pick_found),
    .way       (pick_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      q_type      <= ACC_LOAD;
      q_set       <= '0;
      q_mask      <= '1;
      rsp_install <= 1'b0;
      rsp_victim  <= '0;
      train_en    <= 1'b0;
    end else begin
      train_en <= accept && acc_demand;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            q_type <= req_type;
            q_set  <= req_set;
            q_mask <= req_way_valid;
            if (req_hit) begin
              rsp_install <= 1'b0;
              rsp_victim  <= req_hit_way;
              state       <= ST_RESP;
            end else if (!acc_demand) begin
              rsp_install <= 1'b1;
              rsp_victim  <= '0;
              state       <= ST_RESP;
            end else if (!req_pred_cache) begin
              rsp_install <= 1'b0;
              rsp_victim  <= '0;
              state       <= ST_RESP;
            end else begin
              state <= ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (pick_found) begin
            rsp_install <= 1'b1;
            rsp_victim  <= pick_way;
            state       <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_install) && $stable(rsp_victim))); // R1
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R1
  AST_NONDEMAND_WAY0: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_install && !is_demand(q_type)) |-> (rsp_victim == '0)); // R3
  AST_TRAIN_DEMAND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    train_en |-> $past(accept && is_demand(req_type))); // R8
  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SEARCH) && pick_found && (q_mask != '1)) |-> !q_mask[pick_way]); // R5
  AST_FILL_IS_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH) |-> is_demand(q_type)); // R4
endmodule

// File: tb/tb_access_aware_insert.sv
`timescale 1ns/1ps
module tb_access_aware_insert;
  localparam int SETS = 16;
  localparam int WAYS = 4;

  typedef struct packed {
    logic [1:0] typ;
    logic [3:0] set;
    logic       hit;
    logic [1:0] hway;
    logic       pred;
    logic [3:0] vmask;
    logic       inst;
    logic [1:0] vic;
    logic       train;
    logic [3:0] lat;
  } vec_t;

  localparam int NV = 24;
  // R2 R3 R4 R5 R6 R7 R8 R10: walked in order, RRPV state carries over
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd0, 1'b1, 4'd2}, // R4 fresh set, way0
    '{2'd1, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd1, 1'b1, 4'd2}, // R4 store, way1
    '{2'd0, 4'd1, 1'b0, 2'd0, 1'b0, 4'hF, 1'b0, 2'd0, 1'b1, 4'd1}, // R2 bypass
    '{2'd2, 4'd1, 1'b0, 2'd0, 1'b0, 4'hF, 1'b1, 2'd0, 1'b0, 4'd1}, // R3 writeback
    '{2'd3, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd0, 1'b0, 4'd1}, // R3 prefetch
    '{2'd0, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd2, 1'b1, 4'd2}, // R2 R3 untouched -> way2
    '{2'd0, 4'd1, 1'b1, 2'd3, 1'b0, 4'hF, 1'b0, 2'd3, 1'b1, 4'd1}, // R7 hit way3
    '{2'd0, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd0, 1'b1, 4'd3}, // R6 one aging step
    '{2'd1, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd1, 1'b1, 4'd2}, // R4
    '{2'd0, 4'd1, 1'b0, 2'd0, 1'b1, 4'h7, 1'b1, 2'd3, 1'b1, 4'd2}, // R5 invalid way3 beats way2
    '{2'd1, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd2, 1'b1, 4'd2}, // R4
    '{2'd0, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd0, 1'b1, 4'd3}, // R6
    '{2'd0, 4'd2, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd0, 1'b1, 4'd2}, // R10 other set fresh
    '{2'd3, 4'd1, 1'b1, 2'd1, 1'b0, 4'hF, 1'b0, 2'd1, 1'b0, 4'd1}, // R7 R8 prefetch hit
    '{2'd0, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd2, 1'b1, 4'd2}, // R7 way1 refreshed
    '{2'd1, 4'd1, 1'b0, 2'd0, 1'b0, 4'hF, 1'b0, 2'd0, 1'b1, 4'd1}, // R2 store bypass
    '{2'd0, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd3, 1'b1, 4'd2}, // R2 unchanged -> way3
    '{2'd0, 4'd1, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd0, 1'b1, 4'd3}, // R6
    '{2'd0, 4'd3, 1'b1, 2'd0, 1'b0, 4'hF, 1'b0, 2'd0, 1'b1, 4'd1}, // R7
    '{2'd1, 4'd3, 1'b1, 2'd1, 1'b0, 4'hF, 1'b0, 2'd1, 1'b1, 4'd1}, // R7
    '{2'd0, 4'd3, 1'b1, 2'd2, 1'b0, 4'hF, 1'b0, 2'd2, 1'b1, 4'd1}, // R7
    '{2'd1, 4'd3, 1'b1, 2'd3, 1'b0, 4'hF, 1'b0, 2'd3, 1'b1, 4'd1}, // R7
    '{2'd0, 4'd3, 1'b0, 2'd0, 1'b1, 4'hF, 1'b1, 2'd0, 1'b1, 4'd5}, // R6 three aging steps
    '{2'd1, 4'd4, 1'b0, 2'd0, 1'b1, 4'h9, 1'b1, 2'd1, 1'b1, 4'd2}  // R5 lowest invalid
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_type = '0;
  logic [3:0] req_set = '0;
  logic req_hit = 1'b0;
  logic [1:0] req_hit_way = '0;
  logic req_pred_cache = 1'b0;
  logic [3:0] req_way_valid = '1;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_install;
  logic [1:0] rsp_victim;
  logic train_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  access_aware_insert #(.NUM_SETS(SETS), .NUM_WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_set(req_set), .req_hit(req_hit), .req_hit_way(req_hit_way),
    .req_pred_cache(req_pred_cache), .req_way_valid(req_way_valid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_install(rsp_install),
    .rsp_victim(rsp_victim), .train_en(train_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R9 rsp_valid", int'(rsp_valid), 0);
    chk(train_en == 1'b0, "R9 train", int'(train_en), 0);

    for (int i = 0; i < NV; i++) begin
      int lat;
      req_type = VECS[i].typ;
      req_set = VECS[i].set;
      req_hit = VECS[i].hit;
      req_hit_way = VECS[i].hway;
      req_pred_cache = VECS[i].pred;
      req_way_valid = VECS[i].vmask;
      req_valid = 1'b1;
      chk(req_ready == 1'b1, "R1 idle ready", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      chk(train_en == VECS[i].train, "R8 train pulse", int'(train_en), int'(VECS[i].train));
      while (!rsp_valid && lat < 40) begin
        @(negedge clk);
        lat++;
      end
      chk(rsp_install == VECS[i].inst, "R2/R3/R4 install", int'(rsp_install), int'(VECS[i].inst));
      chk(rsp_victim == VECS[i].vic, "R4/R5/R7 victim", int'(rsp_victim), int'(VECS[i].vic));
      chk(lat == int'(VECS[i].lat), "R6 latency", lat, int'(VECS[i].lat));
      if (lat >= 2)
        chk(train_en == 1'b0, "R8 single cycle", int'(train_en), 0);
      @(negedge clk);
    end

    // R1 back-pressure: writeback miss held while rsp_ready is low
    rsp_ready = 1'b0;
    req_type = 2'd2;
    req_set = 4'd5;
    req_hit = 1'b0;
    req_pred_cache = 1'b0;
    req_way_valid = 4'hF;
    req_valid = 1'b1;
    @(negedge clk);
    req_type = 2'd0;
    req_pred_cache = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(rsp_valid == 1'b1, "R1 held valid", int'(rsp_valid), 1);
      chk(req_ready == 1'b0, "R1 busy", int'(req_ready), 0);
      chk(rsp_install == 1'b1 && rsp_victim == 2'd0, "R1 stable fields", int'(rsp_victim), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 released", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 idle again", int'(req_ready), 1);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 no stray accept", int'(rsp_valid), 0);

    // R10 set 2 untouched by set 1 traffic: second fill goes to way1
    req_type = 2'd0;
    req_set = 4'd2;
    req_pred_cache = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_victim == 2'd1, "R10 set isolation", int'(rsp_victim), 1);
    @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule